// File: doc/BRIEF.md
# Relocatable Memory Map Decoder

This block turns a 16-bit address into one-hot chip selects for three internal targets: a working RAM, a 64-byte control register block and a ROM. Where RAM and the register block sit is set by an 8-bit mapping register. The upper nibble of that register picks the 4 KB page for RAM and the lower nibble picks the 4 KB page for the register block, so the two regions move independently. The ROM sits in one of two fixed pages, chosen by a mode input.

The mapping register is itself one location of the register block, at offset 0x3D, so it moves whenever the block moves. Software may write it once, and only during a short window after reset. The window is counted in cycles on which the cycle-count enable is high. After the one write, or once the window has closed, the register is locked: it still reads back, but it no longer changes.

Selects are combinational from the address and the mode input, and are gated by the read or write strobe. The mapping register updates on the clock edge that accepts a write.

Top module: `memmap_decoder`

## Requirements
- R1: After reset the mapping register reads 0x00 with the default parameters, which places RAM at 0x0040..0x00FF and the register block at 0x0000..0x003F.
- R2: `sel_ram` is asserted for addresses n040..n0FF (hex), where n is mapping register bits 7:4. It is not asserted for n000..n03F or for n100 and above.
- R3: `sel_regs` is asserted for addresses m000..m03F (hex), where m is mapping register bits 3:0.
- R4: With `expanded`=1 the ROM select covers 0x7000..0x7FFF. With `expanded`=0 it covers 0xF000..0xFFFF.
- R5: When regions overlap, the register block wins over RAM and RAM wins over ROM. At most one select is ever high.
- R6: No select is high unless `rd_en` or `wr_en` is high.
- R7: A write to offset 0x3D of the register block inside the window loads `wr_data` into the mapping register and locks it. Any later write leaves the value unchanged.
- R8: The window is open while fewer than 64 enabled cycles have passed since reset. A write on the 64th enabled cycle is accepted. A write after 64 enabled cycles is ignored.
- R9: The mapping register moves with the register block. After relocation to page m it is reached at m03D.
- R10: `map_rdata` shows the mapping register value while `rd_en` is high and the address hits offset 0x3D of the register block. At all other times it is 0x00.
- R11: Cycles with `cyc_en`=0 do not advance the window, so the window does not close while `cyc_en` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cyc_en | input | 1 | Cycle-count enable for the write window |
| addr | input | 16 | Address bus |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data for the mapping register |
| expanded | input | 1 | Mode select: 1 puts ROM at 0x7000, 0 puts it at 0xF000 |
| sel_ram | output | 1 | RAM chip select |
| sel_regs | output | 1 | Register block chip select |
| sel_rom | output | 1 | ROM chip select |
| map_rdata | output | 8 | Mapping register read data |

## Verification
The selects and `map_rdata` depend on the address and strobes in the same cycle, so the bench drives inputs on the falling edge and compares one time unit later, before the next rising edge. A mapping register write takes effect at the rising edge that samples it. Relocated decodes and readbacks are therefore checked from the following falling edge onward. The window boundary is probed by counting rising edges with `cyc_en` high from the release of reset: the write lands on edge 64 in one run and on edge 65 in another.

// File: rtl/memmap_pkg.sv
// Package: shared types for the relocatable memory map decoder.
// Assumes a single address space split into equal pages.
package memmap_pkg;

    // One hit or select flag per decoded target.
    typedef struct packed {
        logic regs;
        logic ram;
        logic rom;
    } target_t;

    localparam target_t TARGET_NONE = '{regs: 1'b0, ram: 1'b0, rom: 1'b0};

endpackage

// File: rtl/memmap_window_reg.sv
// Module: write-once mapping register with a post-reset cycle window.
// Counts enabled cycles up to WINDOW and then locks. An accepted write
// also locks. Assumes wr_req is already qualified by the address decode.
module memmap_window_reg #(
    parameter int DATA_W  = 8,
    parameter int WINDOW  = 64,
    parameter logic [DATA_W-1:0] RST_VAL = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc_en,
    input  logic              wr_req,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] map_q,
    output logic              locked
);
    localparam int CNT_W = $clog2(WINDOW + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WINDOW - 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(WINDOW);

    logic [CNT_W-1:0] cnt_q;
    logic             accept;

    // Purpose: a write lands only while the register is still unlocked.
    always_comb accept = wr_req && !locked;

    // Purpose: the window counter saturates at WINDOW.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (cyc_en && cnt_q != FULL)
            cnt_q <= cnt_q + 1'b1;
    end

    // Purpose: the sticky lock is set by window expiry or by an accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            locked <= 1'b0;
        else if (accept || (cyc_en && cnt_q == LAST))
            locked <= 1'b1;
    end

    // Purpose: hold the mapping value and load it once.
    always_ff @(posedge clk) begin
        if (!rst_n)
            map_q <= RST_VAL;
        else if (accept)
            map_q <= wr_data;
    end
endmodule

// File: rtl/memmap_region_decode.sv
// Module: raw region hits for the register block, RAM and ROM.
// Each region is a span of offsets inside one page. Assumes spans are
// no larger than one page. Overlaps are left to the priority stage.
module memmap_region_decode
    import memmap_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int PAGE_W      = 4,
    parameter int REG_SPAN    = 64,
    parameter int RAM_LO      = 64,
    parameter int RAM_END     = 256,
    parameter int ROM_PG_EXP  = 7,
    parameter int ROM_PG_NORM = 15
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [PAGE_W-1:0] ram_pg,
    input  logic [PAGE_W-1:0] reg_pg,
    input  logic              expanded,
    output target_t           hit
);
    localparam int OFS_W = ADDR_W - PAGE_W;
    localparam logic [OFS_W-1:0] REG_END_O = OFS_W'(REG_SPAN);
    localparam logic [OFS_W-1:0] RAM_LO_O  = OFS_W'(RAM_LO);
    localparam logic [OFS_W-1:0] RAM_END_O = OFS_W'(RAM_END);

    logic [PAGE_W-1:0] pg;
    logic [OFS_W-1:0]  ofs;
    logic [PAGE_W-1:0] rom_pg;

    // Purpose: split the address into page number and in-page offset.
    always_comb begin
        pg  = addr[ADDR_W-1:OFS_W];
        ofs = addr[OFS_W-1:0];
    end

    // Purpose: the mode input picks which fixed page holds the ROM.
    generate
        if (ROM_PG_EXP == ROM_PG_NORM) begin : g_rom_fixed
            always_comb rom_pg = PAGE_W'(ROM_PG_NORM);
        end else begin : g_rom_mode
            always_comb rom_pg = expanded ? PAGE_W'(ROM_PG_EXP) : PAGE_W'(ROM_PG_NORM);
        end
    endgenerate

    // Purpose: compare the page and the offset span for each region.
    always_comb begin
        hit      = TARGET_NONE;
        hit.regs = (pg == reg_pg) && (ofs < REG_END_O);
        hit.ram  = (pg == ram_pg) && (ofs >= RAM_LO_O) && (ofs < RAM_END_O);
        hit.rom  = (pg == rom_pg);
    end
endmodule

// File: rtl/memmap_priority.sv
// Module: fixed-priority select stage gated by the bus strobes.
// Register block beats RAM, RAM beats ROM. Output is one-hot or zero.
module memmap_priority
    import memmap_pkg::*;
(
    input  target_t hit,
    input  logic    strobe,
    output target_t sel
);
    // Purpose: resolve overlaps and gate by the access strobe.
    always_comb begin
        sel = TARGET_NONE;
        if (strobe) begin
            if (hit.regs)
                sel.regs = 1'b1;
            else if (hit.ram)
                sel.ram = 1'b1;
            else if (hit.rom)
                sel.rom = 1'b1;
        end
    end
endmodule

// File: rtl/memmap_decoder.sv
// Module: top of the relocatable memory map decoder.
// The mapping register's upper nibble places RAM and its lower nibble
// places the register block. The register sits at MAP_OFS inside the block.
// Assumes a single-cycle bus with rd_en and wr_en as strobes.
module memmap_decoder
    import memmap_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 8,
    parameter int WINDOW     = 64,
    parameter int REG_PG_RST = 0,
    parameter int MAP_OFS    = 'h3D
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              expanded,
    output logic              sel_ram,
    output logic              sel_regs,
    output logic              sel_rom,
    output logic [DATA_W-1:0] map_rdata
);
    localparam int PAGE_W = DATA_W / 2;
    localparam int OFS_W  = ADDR_W - PAGE_W;
    localparam logic [DATA_W-1:0] MAP_RST = DATA_W'(REG_PG_RST % (1 << PAGE_W));
    localparam logic [OFS_W-1:0]  MAP_OFS_O = OFS_W'(MAP_OFS);

    logic [DATA_W-1:0] map_q;
    logic              locked;
    target_t           hit;
    target_t           sel;
    logic              map_hit;
    logic              strobe;

    // Purpose: the window register holds the page fields.
    memmap_window_reg #(
        .DATA_W (DATA_W),
        .WINDOW (WINDOW),
        .RST_VAL(MAP_RST)
    ) u_map (
        .clk    (clk),
        .rst_n  (rst_n),
        .cyc_en (cyc_en),
        .wr_req (wr_en && map_hit),
        .wr_data(wr_data),
        .map_q  (map_q),
        .locked (locked)
    );

    // Purpose: raw region hits from the current page fields.
    memmap_region_decode #(
        .ADDR_W(ADDR_W),
        .PAGE_W(PAGE_W)
    ) u_dec (
        .addr    (addr),
        .ram_pg  (map_q[DATA_W-1:PAGE_W]),
        .reg_pg  (map_q[PAGE_W-1:0]),
        .expanded(expanded),
        .hit     (hit)
    );

    // Purpose: priority resolution and strobe gating.
    memmap_priority u_pri (
        .hit   (hit),
        .strobe(strobe),
        .sel   (sel)
    );

    // Purpose: the mapping register is hit at its offset inside the register block.
    always_comb begin
        strobe  = rd_en || wr_en;
        map_hit = hit.regs && (addr[OFS_W-1:0] == MAP_OFS_O);
    end

    // Purpose: drive the selects and the mapping register read data.
    always_comb begin
        sel_regs  = sel.regs;
        sel_ram   = sel.ram;
        sel_rom   = sel.rom;
        map_rdata = (rd_en && map_hit) ? map_q : '0;
    end
endmodule

// File: rtl/memmap_decoder_chk.sv
// Module: assertion checker bound to memmap_decoder.
// Watches the selects, the mapping register and its lock flag.
module memmap_decoder_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] addr,
    input logic        rd_en,
    input logic        wr_en,
    input logic        expanded,
    input logic        sel_ram,
    input logic        sel_regs,
    input logic        sel_rom,
    input logic [7:0]  map_q,
    input logic        locked
);
    assert_one_select_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sel_ram, sel_regs, sel_rom}));

    assert_no_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en || wr_en) |-> !(sel_ram || sel_regs || sel_rom));

    assert_ram_span_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sel_ram |-> (addr[15:12] == map_q[7:4]) && (addr[11:8] == 4'h0) && (addr[7:6] != 2'b00));

    assert_regs_span_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sel_regs |-> (addr[15:12] == map_q[3:0]) && (addr[11:6] == 6'h00));

    assert_rom_page_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sel_rom |-> (addr[15:12] == (expanded ? 4'h7 : 4'hF)));

    assert_lock_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> locked);

    assert_locked_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> $stable(map_q));
endmodule

bind memmap_decoder memmap_decoder_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (addr),
    .rd_en   (rd_en),
    .wr_en   (wr_en),
    .expanded(expanded),
    .sel_ram (sel_ram),
    .sel_regs(sel_regs),
    .sel_rom (sel_rom),
    .map_q   (map_q),
    .locked  (locked)
);

// File: tb/memmap_decoder_test.sv
module memmap_decoder_test;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 15;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cyc_en = 1'b0;
    logic [15:0] addr = '0;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_data = '0;
    logic        expanded = 1'b0;
    logic        sel_ram, sel_regs, sel_rom;
    logic [7:0]  map_rdata;

    int n_checks = 0;
    int n_fail = 0;

    memmap_decoder uut (
        .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .addr(addr),
        .rd_en(rd_en), .wr_en(wr_en), .wr_data(wr_data), .expanded(expanded),
        .sel_ram(sel_ram), .sel_regs(sel_regs), .sel_rom(sel_rom),
        .map_rdata(map_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Vector: {tag[3:0], addr[15:0], rd, wr, expanded, sel {regs,ram,rom}}
    localparam logic [25:0] VEC [NVEC] = '{
        {4'd3, 16'h0000, 1'b1, 1'b0, 1'b0, 3'b100},
        {4'd3, 16'h003F, 1'b1, 1'b0, 1'b0, 3'b100},
        {4'd2, 16'h0040, 1'b1, 1'b0, 1'b0, 3'b010},
        {4'd2, 16'h00FF, 1'b0, 1'b1, 1'b0, 3'b010},
        {4'd2, 16'h0100, 1'b1, 1'b0, 1'b0, 3'b000},
        {4'd3, 16'h1000, 1'b1, 1'b0, 1'b0, 3'b000},
        {4'd4, 16'h7000, 1'b1, 1'b0, 1'b1, 3'b001},
        {4'd4, 16'h7FFF, 1'b0, 1'b1, 1'b1, 3'b001},
        {4'd4, 16'h7000, 1'b1, 1'b0, 1'b0, 3'b000},
        {4'd4, 16'hF000, 1'b1, 1'b0, 1'b0, 3'b001},
        {4'd4, 16'hFFFF, 1'b1, 1'b0, 1'b0, 3'b001},
        {4'd4, 16'hF000, 1'b1, 1'b0, 1'b1, 3'b000},
        {4'd6, 16'h0040, 1'b0, 1'b0, 1'b0, 3'b000},
        {4'd6, 16'hF000, 1'b0, 1'b0, 1'b0, 3'b000},
        {4'd6, 16'h0000, 1'b0, 1'b0, 1'b1, 3'b000}
    };

    function automatic string tag_name(input logic [3:0] t);
        case (t)
            4'd2: tag_name = "R2";
            4'd3: tag_name = "R3";
            4'd4: tag_name = "R4";
            4'd6: tag_name = "R6";
            default: tag_name = "R?";
        endcase
    endfunction

    task automatic check_val(input string req, input string what,
                             input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Drive at the falling edge, then compare 1 time unit later.
    task automatic probe(input logic [15:0] a, input logic r, input logic w,
                         input logic e, input logic [2:0] exp_sel,
                         input logic [7:0] exp_rd, input string req);
        @(negedge clk);
        addr = a; rd_en = r; wr_en = w; expanded = e; cyc_en = 1'b0;
        #1;
        check_val(req, "sel{regs,ram,rom}", {5'b0, sel_regs, sel_ram, sel_rom}, {5'b0, exp_sel});
        check_val(req, "map_rdata", map_rdata, exp_rd);
        rd_en = 1'b0; wr_en = 1'b0;
    endtask

    task automatic do_reset;
        @(negedge clk);
        rst_n = 1'b0; rd_en = 1'b0; wr_en = 1'b0; cyc_en = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // n rising edges with the cycle-count enable set to en.
    task automatic idle(input int n, input logic en);
        @(negedge clk);
        rd_en = 1'b0; wr_en = 1'b0; cyc_en = en;
        repeat (n) @(posedge clk);
    endtask

    // One write cycle with cyc_en high; it lands at the next rising edge.
    task automatic write_map(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1; rd_en = 1'b0; cyc_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; cyc_en = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        do_reset();
        // R1: reset value and default layout
        probe(16'h003D, 1'b1, 1'b0, 1'b0, 3'b100, 8'h00, "R1");

        // Vector table walked under the reset mapping.
        for (int i = 0; i < NVEC; i++) begin
            probe(VEC[i][21:6], VEC[i][5], VEC[i][4], VEC[i][3], VEC[i][2:0],
                  8'h00, tag_name(VEC[i][25:22]));
        end

        // R10: no read strobe gives zero read data
        probe(16'h003D, 1'b0, 1'b1, 1'b0, 3'b100, 8'h00, "R10");
        probe(16'h003C, 1'b1, 1'b0, 1'b0, 3'b100, 8'h00, "R10");

        // R7 / R9: relocate RAM to page 5 and the block to page 3
        do_reset();
        write_map(16'h003D, 8'h53);
        probe(16'h303D, 1'b1, 1'b0, 1'b0, 3'b100, 8'h53, "R9");
        probe(16'h003D, 1'b1, 1'b0, 1'b0, 3'b000, 8'h00, "R9");
        probe(16'h3000, 1'b1, 1'b0, 1'b0, 3'b100, 8'h00, "R3");
        probe(16'h5040, 1'b1, 1'b0, 1'b0, 3'b010, 8'h00, "R2");
        probe(16'h50FF, 1'b1, 1'b0, 1'b0, 3'b010, 8'h00, "R2");
        probe(16'h5000, 1'b1, 1'b0, 1'b0, 3'b000, 8'h00, "R2");
        probe(16'h0040, 1'b1, 1'b0, 1'b0, 3'b000, 8'h00, "R2");
        write_map(16'h303D, 8'h77);
        probe(16'h303D, 1'b1, 1'b0, 1'b0, 3'b100, 8'h53, "R7");

        // R5: both regions in page 7 with ROM also at page 7
        do_reset();
        write_map(16'h003D, 8'h77);
        probe(16'h7000, 1'b1, 1'b0, 1'b1, 3'b100, 8'h00, "R5");
        probe(16'h7040, 1'b1, 1'b0, 1'b1, 3'b010, 8'h00, "R5");
        probe(16'h7100, 1'b1, 1'b0, 1'b1, 3'b001, 8'h00, "R5");
        probe(16'h703D, 1'b1, 1'b0, 1'b1, 3'b100, 8'h77, "R5");

        // R8: write on the 64th enabled edge is accepted
        do_reset();
        idle(63, 1'b1);
        write_map(16'h003D, 8'h21);
        probe(16'h103D, 1'b1, 1'b0, 1'b0, 3'b100, 8'h21, "R8");

        // R8: write on the 65th enabled edge is ignored
        do_reset();
        idle(64, 1'b1);
        write_map(16'h003D, 8'h21);
        probe(16'h003D, 1'b1, 1'b0, 1'b0, 3'b100, 8'h00, "R8");
        probe(16'h103D, 1'b1, 1'b0, 1'b0, 3'b000, 8'h00, "R8");

        // R11: cycles without cyc_en do not close the window
        do_reset();
        idle(200, 1'b0);
        write_map(16'h003D, 8'h42);
        probe(16'h203D, 1'b1, 1'b0, 1'b0, 3'b100, 8'h42, "R11");
        probe(16'h4040, 1'b1, 1'b0, 1'b0, 3'b010, 8'h00, "R11");

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule